// File: doc/BRIEF.md
# Strided Vector Address Sequencer

This block produces the stream of memory word addresses for a single vector load or store. A command names an addressing mode, a base word address, a stride, and the total element count. In unit mode each address is one word above the last. In strided mode the element address grows by a signed stride on every step. In indexed mode each address is the base plus an offset taken from an index stream, which serves both gathers and scatters. After a fixed startup latency the block issues at most one address per clock. Each address is tagged with its bank, its element number in the whole vector, and its lane, which is its position inside the current strip.

Long vectors are cut into strips of at most `MVL` elements. The first strip holds the count modulo `MVL` and every later strip is full. When that first remainder is zero, the strip is dropped with no cycle spent on it. Every bank keeps a busy counter that is loaded whenever that bank is addressed. The sequencer does not issue to a bank that is still busy. While it waits it raises `stall` and keeps the pending address on the output.

The control is a four-state machine:
- `ST_IDLE` waits for a command. The transition idle→lat happens when a command is accepted.
- `ST_LAT` counts out the startup latency. When the count runs out, lat→issue is taken if any element is left, and lat→done is taken for an empty vector.
- `ST_ISSUE` hands out addresses. When the last element of the last strip is accepted, issue→done is taken.
- `ST_DONE` lasts one cycle and always goes back to `ST_IDLE` (done→idle).

Top module: `vas_seq_top`

## Requirements
- R1: After reset, and whenever the block is idle, `cmd_ready` is 1 and `out_valid`, `stall` and `done` are 0.
- R2: Mode code 2'b00 (unit) gives address base+i for element i. `out_bank` always equals the address modulo `NUM_BANKS`, which is the low `log2(NUM_BANKS)` address bits.
- R3: Mode code 2'b01 (strided) gives address base + i×stride modulo 2^ADDR_W, so a negative stride in two's complement works as well.
- R4: Mode code 2'b10 (indexed) gives address base + index(i), where index(i) is the i-th word taken on the index stream. Exactly one index is consumed for each address accepted.
- R5: For a count n, the first strip holds n mod `MVL` elements with lanes 0 upward. Every later strip holds `MVL` elements with lanes 0..MVL-1. `out_elem` counts 0..n-1 across all strips.
- R6: When n is a multiple of `MVL`, the zero-length first strip costs no cycle and issues no address, so lane 0 comes first. For n=0 no address is issued and `done` appears `START_LAT` cycles after acceptance.
- R7: The first address becomes valid `START_LAT` (12) cycles after the command is accepted. After that one address is accepted per cycle as long as no bank or output wait occurs.
- R8: A bank addressed in cycle t is not addressed again before cycle t+`BUSY_TIME`. While the next element waits on such a bank, `stall` is 1 and `out_addr` holds its value.
- R9: `done` is a single-cycle pulse one cycle after the last address is accepted. It is followed by `cmd_ready`.
- R10: While `out_valid` is 1 and `out_ready` is 0, the element does not advance and `out_addr` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Sequencer idle, command taken |
| cmd_mode | input | 2 | 00 unit, 01 strided, 10 indexed |
| cmd_base | input | ADDR_W | Base word address |
| cmd_stride | input | ADDR_W | Stride in words (two's complement) |
| cmd_len | input | LEN_W | Total element count |
| idx_valid | input | 1 | Index word offered |
| idx_ready | output | 1 | Index word consumed |
| idx_data | input | ADDR_W | Index offset in words |
| out_valid | output | 1 | Address available |
| out_ready | input | 1 | Address accepted by memory side |
| out_addr | output | ADDR_W | Element word address |
| out_bank | output | log2(NUM_BANKS) | Target bank |
| out_elem | output | LEN_W | Element number in the vector |
| out_lane | output | log2(MVL) | Position inside the current strip |
| stall | output | 1 | Next element waits on a busy bank |
| done | output | 1 | Vector finished pulse |

## Verification
For each element the bench works out the cycle in which the address should be accepted. The first one is due 12 cycles after the acceptance edge. Each later one is due one cycle after the previous one, pushed back to the cycle its bank becomes free and past any cycle in which the bench withholds `out_ready`. The bench compares the actual acceptance cycle, read from its own cycle counter at the falling edge, against that prediction. `done` is expected exactly one cycle after the last acceptance, or 12 cycles after acceptance for an empty vector. The total number of cycles with `stall` raised must equal the bank wait cycles the bench predicts.

// File: rtl/vas_pkg.sv
package vas_pkg;

    typedef enum logic [1:0] {
        MODE_UNIT   = 2'b00,
        MODE_STRIDE = 2'b01,
        MODE_INDEX  = 2'b10
    } vas_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LAT,
        ST_ISSUE,
        ST_DONE
    } vas_state_e;

endpackage

// File: rtl/vas_bank_track.sv
module vas_bank_track #(
    parameter int NUM_BANKS = 8,
    parameter int BUSY_TIME = 4,
    parameter int BANK_W    = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hit,
    input  logic [BANK_W-1:0] hit_bank,
    input  logic [BANK_W-1:0] query_bank,
    output logic              query_busy
);
    localparam int CW = $clog2(BUSY_TIME + 1);
    localparam logic [CW-1:0] LOAD = CW'(BUSY_TIME - 1);

    logic [NUM_BANKS-1:0] busy_vec;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [CW-1:0] cnt_q;
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cnt_q <= '0;
            end else if (hit && hit_bank == BANK_W'(b)) begin
                cnt_q <= LOAD;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
        assign busy_vec[b] = (cnt_q != '0);
    end

    assign query_busy = busy_vec[query_bank];

endmodule

// File: rtl/vas_addr_gen.sv
module vas_addr_gen
    import vas_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              advance,
    input  logic [1:0]        mode,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] stride,
    input  logic [ADDR_W-1:0] idx_data,
    output logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank
);
    logic [ADDR_W-1:0] offset_q;
    logic [ADDR_W-1:0] step;

    always_comb begin
        step = (mode == MODE_STRIDE) ? stride : ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            offset_q <= '0;
        end else if (advance) begin
            offset_q <= offset_q + step;
        end
    end

    always_comb begin
        addr = base + ((mode == MODE_INDEX) ? idx_data : offset_q);
        bank = addr[BANK_W-1:0];
    end

endmodule

// File: rtl/vas_seq_top.sv
module vas_seq_top
    import vas_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int LEN_W     = 16,
    parameter int MVL       = 64,
    parameter int NUM_BANKS = 8,
    parameter int BUSY_TIME = 4,
    parameter int START_LAT = 12,
    localparam int LANE_W   = $clog2(MVL),
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [1:0]        cmd_mode,
    input  logic [ADDR_W-1:0] cmd_base,
    input  logic [ADDR_W-1:0] cmd_stride,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              idx_valid,
    output logic              idx_ready,
    input  logic [ADDR_W-1:0] idx_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [ADDR_W-1:0] out_addr,
    output logic [BANK_W-1:0] out_bank,
    output logic [LEN_W-1:0]  out_elem,
    output logic [LANE_W-1:0] out_lane,
    output logic              stall,
    output logic              done
);
    localparam int LAT_W = $clog2(START_LAT + 1);
    localparam logic [LAT_W-1:0]  LAT_LOAD = LAT_W'(START_LAT - 1);
    localparam logic [LANE_W:0]   FULL_STRIP = (LANE_W + 1)'(MVL);

    vas_state_e        state_q, state_d;
    logic [LAT_W-1:0]  lat_q;
    logic [LANE_W:0]   strip_rem_q;
    logic [LEN_W-1:0]  strips_left_q;
    logic [LEN_W-1:0]  elem_q;
    logic [LANE_W-1:0] lane_q;
    logic [LEN_W-1:0]  len_q;
    logic [1:0]        mode_q;
    logic [ADDR_W-1:0] base_q, stride_q;

    logic start, fire, idx_mode, src_ok, in_issue, bank_busy;
    logic last_of_strip, more_strips;

    assign start         = cmd_valid && (state_q == ST_IDLE);
    assign idx_mode      = (mode_q == MODE_INDEX);
    assign src_ok        = !idx_mode || idx_valid;
    assign in_issue      = (state_q == ST_ISSUE);
    assign last_of_strip = (strip_rem_q == (LANE_W + 1)'(1));
    assign more_strips   = (strips_left_q != '0);
    assign fire          = out_valid && out_ready;

    vas_addr_gen #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (start),
        .advance  (fire),
        .mode     (mode_q),
        .base     (base_q),
        .stride   (stride_q),
        .idx_data (idx_data),
        .addr     (out_addr),
        .bank     (out_bank)
    );

    vas_bank_track #(.NUM_BANKS(NUM_BANKS), .BUSY_TIME(BUSY_TIME), .BANK_W(BANK_W)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (fire),
        .hit_bank   (out_bank),
        .query_bank (out_bank),
        .query_busy (bank_busy)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (cmd_valid) state_d = ST_LAT;
            ST_LAT: begin
                if (lat_q == '0) begin
                    if (strip_rem_q != '0 || more_strips) state_d = ST_ISSUE;
                    else                                  state_d = ST_DONE;
                end
            end
            ST_ISSUE: if (fire && last_of_strip && !more_strips) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // strip, element and latency counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q         <= '0;
            strip_rem_q   <= '0;
            strips_left_q <= '0;
            elem_q        <= '0;
            lane_q        <= '0;
            len_q         <= '0;
            mode_q        <= MODE_UNIT;
            base_q        <= '0;
            stride_q      <= '0;
        end else if (start) begin
            lat_q         <= LAT_LOAD;
            strip_rem_q   <= {1'b0, cmd_len[LANE_W-1:0]};
            strips_left_q <= cmd_len >> LANE_W;
            elem_q        <= '0;
            lane_q        <= '0;
            len_q         <= cmd_len;
            mode_q        <= cmd_mode;
            base_q        <= cmd_base;
            stride_q      <= cmd_stride;
        end else if (state_q == ST_LAT) begin
            if (lat_q != '0) begin
                lat_q <= lat_q - 1'b1;
            end else if (strip_rem_q == '0 && more_strips) begin
                strip_rem_q   <= FULL_STRIP;
                strips_left_q <= strips_left_q - 1'b1;
            end
        end else if (in_issue && fire) begin
            elem_q <= elem_q + 1'b1;
            if (last_of_strip) begin
                lane_q <= '0;
                if (more_strips) begin
                    strip_rem_q   <= FULL_STRIP;
                    strips_left_q <= strips_left_q - 1'b1;
                end else begin
                    strip_rem_q <= '0;
                end
            end else begin
                lane_q      <= lane_q + 1'b1;
                strip_rem_q <= strip_rem_q - 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        cmd_ready = (state_q == ST_IDLE);
        done      = (state_q == ST_DONE);
        out_valid = in_issue && src_ok && !bank_busy;
        stall     = in_issue && src_ok && bank_busy;
        idx_ready = in_issue && idx_mode && !bank_busy && out_ready;
        out_elem  = elem_q;
        out_lane  = lane_q;
    end

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_ready |-> (!out_valid && !stall && !done)); // R1
    AST_ELEM_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_elem < len_q)); // R5
    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stall && !idx_mode) |=> $stable(out_addr)); // R8
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && cmd_ready)); // R9
    AST_BACKPRESSURE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready && !idx_mode) |=> (out_valid && $stable(out_addr))); // R10

endmodule

// File: tb/sim_vas_seq_top.sv
module sim_vas_seq_top;
    localparam int AW = 32;
    localparam int LW = 16;
    localparam int MV = 64;
    localparam int NB = 8;
    localparam int BT = 4;
    localparam int SL = 12;

    logic clk = 0;
    logic rst_n = 0;
    logic cmd_valid = 0;
    logic cmd_ready;
    logic [1:0] cmd_mode = 0;
    logic [AW-1:0] cmd_base = 0, cmd_stride = 0;
    logic [LW-1:0] cmd_len = 0;
    logic idx_valid = 0;
    logic idx_ready;
    logic [AW-1:0] idx_data = 0;
    logic out_valid;
    logic out_ready = 1;
    logic [AW-1:0] out_addr;
    logic [2:0] out_bank;
    logic [LW-1:0] out_elem;
    logic [5:0] out_lane;
    logic stall, done;

    int checks = 0, failures = 0;
    longint cyc = 0;
    bit bp_en = 0;
    bit finished = 0;

    always #10 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    vas_seq_top #(.ADDR_W(AW), .LEN_W(LW), .MVL(MV), .NUM_BANKS(NB),
                  .BUSY_TIME(BT), .START_LAT(SL)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_mode(cmd_mode), .cmd_base(cmd_base), .cmd_stride(cmd_stride),
        .cmd_len(cmd_len), .idx_valid(idx_valid), .idx_ready(idx_ready),
        .idx_data(idx_data), .out_valid(out_valid), .out_ready(out_ready),
        .out_addr(out_addr), .out_bank(out_bank), .out_elem(out_elem),
        .out_lane(out_lane), .stall(stall), .done(done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic bit rdy(input longint t);
        return !(bp_en && (t % 3 == 0));
    endfunction

    function automatic logic [AW-1:0] idx_fn(input int i);
        return AW'((i * 13 + 3) & 255);
    endfunction

    task automatic run_vec(input logic [1:0] mode, input logic [AW-1:0] base,
                           input logic [AW-1:0] stride, input int len, input bit bp);
        longint bf[NB];
        longint a, prev, lo, et, c;
        logic [AW-1:0] ea;
        int i, eb, first, elane, nidx, stall_seen, stall_exp, guard;
        bit need, bank_del, rdy_del;
        string atag, ltag, ttag;
        foreach (bf[k]) bf[k] = 0;
        atag = (mode == 2'b00) ? "R2" : (mode == 2'b01) ? "R3" : "R4";
        ltag = (len % MV == 0) ? "R6" : "R5";
        first = len % MV;
        bp_en = bp;
        @(negedge clk);
        cmd_mode = mode; cmd_base = base; cmd_stride = stride;
        cmd_len = LW'(len); cmd_valid = 1;
        @(negedge clk);
        a = cyc; cmd_valid = 0;
        i = 0; prev = 0; need = 1; nidx = 0; stall_seen = 0; stall_exp = 0; guard = 0;
        ea = 0; eb = 0; et = 0; bank_del = 0; rdy_del = 0;
        forever begin
            if (need && i < len) begin
                case (mode)
                    2'b00:   ea = base + AW'(i);
                    2'b01:   ea = base + AW'(i) * stride;
                    default: ea = base + idx_fn(i);
                endcase
                eb = int'(ea % NB);
                lo = (i == 0) ? a + SL : prev + 1;
                et = (bf[eb] > lo) ? bf[eb] : lo;
                bank_del = (bf[eb] > lo);
                if (bank_del) stall_exp += int'(bf[eb] - lo);
                rdy_del = 0;
                while (!rdy(et)) begin et++; rdy_del = 1; end
                need = 0;
            end
            c = cyc;
            out_ready = rdy(c);
            idx_data = idx_fn(i);
            idx_valid = 1;
            #1;
            if (idx_valid && idx_ready) nidx++;
            if (done) begin
                chk(i == len, "R9", "elements before done", i, len);
                chk(c == ((len == 0) ? a + SL : prev + 1), (len == 0) ? "R6" : "R9",
                    "done cycle", c, (len == 0) ? a + SL : prev + 1);
                break;
            end
            if (i < len) begin
                if (out_valid && out_ready) begin
                    ttag = bank_del ? "R8" : (rdy_del ? "R10" : "R7");
                    chk(c == et, ttag, "accept cycle", c, et);
                    chk(out_addr == ea, atag, "address", out_addr, ea);
                    chk(out_bank == ea[2:0], "R2", "bank", out_bank, ea[2:0]);
                    chk(out_elem == LW'(i), "R5", "element number", out_elem, i);
                    elane = (i < first) ? i : (i - first) % MV;
                    chk(out_lane == 6'(elane), ltag, "lane", out_lane, elane);
                    bf[eb] = c + BT;
                    prev = c; i++; need = 1;
                end else if (stall) begin
                    stall_seen++;
                    chk(out_addr == ea, "R8", "held address in stall", out_addr, ea);
                end else if (out_valid) begin
                    chk(out_addr == ea, "R10", "held address under backpressure", out_addr, ea);
                end
            end
            guard++;
            if (guard > 5000) begin
                chk(0, "R9", "sequence timeout", guard, 0);
                break;
            end
            @(negedge clk);
        end
        chk(stall_seen == stall_exp, "R8", "stall cycles", stall_seen, stall_exp);
        if (mode == 2'b10) chk(nidx == len, "R4", "indices consumed", nidx, len);
        @(negedge clk);
        chk(!done && cmd_ready, "R9", "done single pulse then ready", done, 0);
        bp_en = 0; out_ready = 1; idx_valid = 0;
    endtask

    task automatic test_reset();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready == 1, "R1", "cmd_ready after reset", cmd_ready, 1);
        chk(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
        chk(stall == 0 && done == 0, "R1", "stall/done after reset", {stall, done}, 0);
    endtask

    task automatic test_unit();      run_vec(2'b00, 32'd100, 32'd0, 10, 0);   endtask // R2 R7
    task automatic test_stride();    run_vec(2'b01, 32'd40, 32'd3, 20, 0);    endtask // R3
    task automatic test_neg_stride();run_vec(2'b01, 32'd500, 32'hFFFF_FFFE, 9, 0); endtask // R3
    task automatic test_conflict8(); run_vec(2'b01, 32'd7, 32'd8, 9, 0);      endtask // R8
    task automatic test_conflict4(); run_vec(2'b01, 32'd0, 32'd4, 12, 0);     endtask // R8
    task automatic test_indexed();   run_vec(2'b10, 32'd1000, 32'd0, 30, 0);  endtask // R4
    task automatic test_strips();    run_vec(2'b00, 32'd0, 32'd0, 70, 0);     endtask // R5
    task automatic test_exact();     run_vec(2'b01, 32'd11, 32'd5, 128, 0);   endtask // R6
    task automatic test_empty();     run_vec(2'b00, 32'd0, 32'd0, 0, 0);      endtask // R6
    task automatic test_backpress(); run_vec(2'b00, 32'd64, 32'd0, 8, 1);     endtask // R10

    initial begin
        test_reset();
        test_unit();
        test_stride();
        test_neg_stride();
        test_conflict8();
        test_conflict4();
        test_indexed();
        test_strips();
        test_exact();
        test_empty();
        test_backpress();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 50000, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule